// File: doc/BRIEF.md
# Sticky-Flag Interrupt Collector

This block gathers ten interrupt sources into two status groups and presents one level-sensitive interrupt request to a CPU. The function group holds a timer event, two external pin events and a periodic keyboard tick. The bus group holds three IN-complete events, one OUT-complete event, a setup-complete event and a suspend event. All sources share one vector, so the block resolves no priority and provides no vector.

Each event sets a flag that stays set until software clears it. Software clears a flag by writing a 1 to the same bit of the group's clear register. Writing a 0 clears nothing. Software cannot set a flag directly. Each group also has an enable register, which can be read and written. A flag whose enable bit is 0 still latches and can be read, but it does not raise the request. The two external pins pass through a two-flop synchronizer, and a high-to-low transition on a pin sets its flag. The other sources arrive as one-cycle pulses.

All registers sit on a byte-wide register bus with a 3-bit address. Bit 2 of the address selects the group: 0 selects the function group and 1 selects the bus group. Bits 1:0 select the register: 0 is the flags, 1 is the clear register and 2 is the enable register. Reads return data in the same cycle.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, every address reads 00h and `irq` is 0.
- R2: The function flag register (address 0) holds the timer event in bit 0, the falling edge of pin A in bit 1, the falling edge of pin B in bit 2 and the keyboard tick in bit 3. Bits 7:4 read 0.
- R3: The bus flag register (address 4) holds IN0 in bit 0, OUT0 in bit 1, IN1 in bit 2, IN2 in bit 3, setup in bit 6 and suspend in bit 7. Bits 5:4 read 0.
- R4: A flag stays set until a write to its group's clear register (address 1 or 5) has a 1 in that flag's bit. Clear bits written as 0 leave their flags unchanged.
- R5: Writes to a flag address never change the flags. The clear registers and addresses 3 and 7 always read 00h.
- R6: `irq` is 1 exactly when some flag and its enable bit are both 1, in either group, and it follows the flags and enables in the same cycle. A flag whose enable bit is 0 still sets and can be read.
- R7: A pin flag is set at the third rising clock edge after the pin is first sampled low. A rising edge on a pin, or a pin held at a steady level, sets nothing.
- R8: If a source event and a clear write for the same flag fall in the same cycle, the flag ends that cycle set.
- R9: The enable registers (address 2 and address 6) read back the written value masked to the valid flag bits (0Fh for the function group, CFh for the bus group). An enable register changes only when it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin_a | input | 1 | Asynchronous pin A, falling-edge event |
| ext_pin_b | input | 1 | Asynchronous pin B, falling-edge event |
| tmr_evt | input | 1 | Timer overflow pulse |
| kbd_evt | input | 1 | Keyboard tick pulse |
| in0_evt | input | 1 | IN-complete pulse, endpoint 0 |
| out0_evt | input | 1 | OUT-complete pulse, endpoint 0 |
| in1_evt | input | 1 | IN-complete pulse, endpoint 1 |
| in2_evt | input | 1 | IN-complete pulse, endpoint 2 |
| setup_evt | input | 1 | Setup-complete pulse |
| susp_evt | input | 1 | Suspend detected pulse |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| irq | output | 1 | Level interrupt request |

## Verification
Timing through the block:

- **Pulse sources:** a pulse or clear write applied before a rising edge shows in the flags right after that edge.
- **Reads and `irq`:** read data and `irq` follow the registers with no further delay.
- **Pins:** a pin transition takes three edges to reach its flag: two synchronizer stages, then the edge compare.

The bench drives inputs and samples outputs on the falling clock edge. A reference model in the bench steps once per rising edge with the same delays. Directed peeks are placed at the exact edge count the timing above gives, including one edge early for the pin flag.

// File: rtl/irq_flag_ctrl_pkg.sv
package irq_flag_ctrl_pkg;
  localparam int REG_W    = 8;
  localparam int ADDR_W   = 3;
  localparam int GRP_BIT  = 2;
  localparam logic [REG_W-1:0] FN_MASK  = 8'h0F;
  localparam logic [REG_W-1:0] BUS_MASK = 8'hCF;

  typedef enum logic [1:0] {
    OFS_FLAG = 2'd0,
    OFS_CLR  = 2'd1,
    OFS_EN   = 2'd2,
    OFS_NONE = 2'd3
  } reg_ofs_e;

  // New flag value: set has priority over clear, invalid bits forced low
  function automatic logic [REG_W-1:0] flag_next(input logic [REG_W-1:0] cur,
                                                 input logic [REG_W-1:0] set,
                                                 input logic [REG_W-1:0] clr,
                                                 input logic [REG_W-1:0] mask);
    return ((cur & ~clr) | set) & mask;
  endfunction

  function automatic logic [REG_W-1:0] wr_strobe(input logic wr, input logic hit,
                                                 input logic [REG_W-1:0] d);
    return (wr && hit) ? d : '0;
  endfunction

  function automatic logic any_pending(input logic [REG_W-1:0] flags,
                                       input logic [REG_W-1:0] en);
    return |(flags & en);
  endfunction
endpackage

// File: rtl/irq_fall_detect.sv
module irq_fall_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= pin;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[STAGES-2:0], pin};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sync_q[LAST];
  end

  assign fall = prev_q & ~sync_q[LAST];
endmodule

// File: rtl/irq_flag_group.sv
module irq_flag_group
  import irq_flag_ctrl_pkg::*;
#(
  parameter logic [REG_W-1:0] MASK = 8'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] set_vec,
  input  logic [REG_W-1:0] clr_vec,
  input  logic             en_wr,
  input  logic [REG_W-1:0] en_data,
  output logic [REG_W-1:0] flags,
  output logic [REG_W-1:0] enables
);
  logic [REG_W-1:0] flags_q, en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      en_q    <= '0;
    end else begin
      flags_q <= flag_next(flags_q, set_vec, clr_vec, MASK);
      if (en_wr) en_q <= en_data & MASK;
    end
  end

  assign flags   = flags_q;
  assign enables = en_q;
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_flag_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_pin_a,
  input  logic              ext_pin_b,
  input  logic              tmr_evt,
  input  logic              kbd_evt,
  input  logic              in0_evt,
  input  logic              out0_evt,
  input  logic              in1_evt,
  input  logic              in2_evt,
  input  logic              setup_evt,
  input  logic              susp_evt,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq
);
  localparam int N_PINS = 2;

  logic [N_PINS-1:0] pin_vec, pin_fall;
  assign pin_vec = {ext_pin_b, ext_pin_a};

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    irq_fall_detect #(.STAGES(SYNC_STAGES)) u_fd (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (pin_vec[g]),
      .fall (pin_fall[g])
    );
  end

  // Decode of the register bus
  logic     sel_bus;
  reg_ofs_e ofs;
  assign sel_bus = reg_addr[GRP_BIT];
  assign ofs     = reg_ofs_e'(reg_addr[1:0]);

  // Named internal events (also observed by the checker)
  logic [REG_W-1:0] fn_set, bus_set, fn_clr, bus_clr;
  logic             fn_en_wr, bus_en_wr, en_wr;
  logic [REG_W-1:0] fn_flags, bus_flags, fn_en, bus_en;

  assign fn_set  = {4'b0000, kbd_evt, pin_fall[1], pin_fall[0], tmr_evt};
  assign bus_set = {susp_evt, setup_evt, 2'b00, in2_evt, in1_evt, out0_evt, in0_evt};

  assign fn_clr    = wr_strobe(reg_wr, !sel_bus && ofs == OFS_CLR, reg_wdata);
  assign bus_clr   = wr_strobe(reg_wr,  sel_bus && ofs == OFS_CLR, reg_wdata);
  assign fn_en_wr  = reg_wr && !sel_bus && ofs == OFS_EN;
  assign bus_en_wr = reg_wr &&  sel_bus && ofs == OFS_EN;
  assign en_wr     = fn_en_wr | bus_en_wr;

  irq_flag_group #(.MASK(FN_MASK)) u_fn_grp (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_vec(fn_set),
    .clr_vec(fn_clr),
    .en_wr  (fn_en_wr),
    .en_data(reg_wdata),
    .flags  (fn_flags),
    .enables(fn_en)
  );

  irq_flag_group #(.MASK(BUS_MASK)) u_bus_grp (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_vec(bus_set),
    .clr_vec(bus_clr),
    .en_wr  (bus_en_wr),
    .en_data(reg_wdata),
    .flags  (bus_flags),
    .enables(bus_en)
  );

  // Read mux
  always_comb begin
    reg_rdata = '0;
    unique case (ofs)
      OFS_FLAG: reg_rdata = sel_bus ? bus_flags : fn_flags;
      OFS_EN:   reg_rdata = sel_bus ? bus_en    : fn_en;
      default:  reg_rdata = '0;
    endcase
  end

  assign irq = any_pending(fn_flags, fn_en) | any_pending(bus_flags, bus_en);
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        irq,
  input logic [15:0] all_flags,
  input logic [15:0] all_set,
  input logic [15:0] all_clr,
  input logic [15:0] all_en,
  input logic        en_wr
);
  // R4
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((all_flags & $past(all_flags & ~all_clr)) == $past(all_flags & ~all_clr)));

  // R5
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((all_flags & ~$past(all_flags) & ~$past(all_set)) == 16'h0000));

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((all_flags & $past(all_set)) == $past(all_set)));

  // R6
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && all_clr == 16'h0000 && !en_wr) |=> irq);

  // R9
  en_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(all_en));
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq      (irq),
  .all_flags({bus_flags, fn_flags}),
  .all_set  ({bus_set, fn_set}),
  .all_clr  ({bus_clr, fn_clr}),
  .all_en   ({bus_en, fn_en}),
  .en_wr    (en_wr)
);

// File: tb/irq_flag_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_flag_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pa = 1'b1, pb = 1'b1;
  logic       tmr = 0, kbd = 0, in0 = 0, out0 = 0, in1 = 0, in2 = 0, stp = 0, sus = 0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int unsigned seed_v;

  always #5 clk = ~clk;

  irq_flag_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ext_pin_a(pa), .ext_pin_b(pb),
    .tmr_evt(tmr), .kbd_evt(kbd), .in0_evt(in0), .out0_evt(out0),
    .in1_evt(in1), .in2_evt(in2), .setup_evt(stp), .susp_evt(sus),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  // Reference model state
  logic [7:0] m_fn = 0, m_bus = 0, m_fen = 0, m_ben = 0;
  logic [1:0] ms1 = 2'b11, ms2 = 2'b11, mprv = 2'b11;

  function automatic logic [7:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return m_fn;
      3'd2: return m_fen;
      3'd4: return m_bus;
      3'd6: return m_ben;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic model_irq();
    return ((m_fn & m_fen) != 0) || ((m_bus & m_ben) != 0);
  endfunction

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic peek(input string tag, input logic [2:0] a, input logic [7:0] exp);
    logic [2:0] keep;
    keep = reg_addr;
    reg_addr = a;
    #1;
    check8(tag, reg_rdata, exp);
    reg_addr = keep;
    #1;
  endtask

  task automatic peek_irq(input string tag, input logic exp);
    check8(tag, {7'd0, irq}, {7'd0, exp});
  endtask

  // pulses: bit0 tmr, 1 kbd, 2 in0, 3 out0, 4 in1, 5 in2, 6 setup, 7 suspend
  task automatic step(input logic [7:0] p, input logic npa, input logic npb,
                      input logic wr, input logic [2:0] a, input logic [7:0] d);
    logic [1:0] fallv;
    logic [7:0] cf, cb;
    // compare state of the previous edge (R4 R6 model)
    check8("R4 R6 rdata", reg_rdata, model_read(reg_addr));
    check8("R6 irq", {7'd0, irq}, {7'd0, model_irq()});
    {sus, stp, in2, in1, out0, in0, kbd, tmr} = p;
    pa = npa; pb = npb;
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    fallv = mprv & ~ms2;
    cf = (wr && a == 3'd1) ? d : 8'h00;
    cb = (wr && a == 3'd5) ? d : 8'h00;
    @(posedge clk);
    m_fn  = ((m_fn  & ~cf) | {4'b0, p[1], fallv[1], fallv[0], p[0]}) & 8'h0F;
    m_bus = ((m_bus & ~cb) | {p[7], p[6], 2'b0, p[5], p[4], p[3], p[2]}) & 8'hCF;
    if (wr && a == 3'd2) m_fen = d & 8'h0F;
    if (wr && a == 3'd6) m_ben = d & 8'hCF;
    mprv = ms2; ms2 = ms1; ms1 = {npb, npa};
    @(negedge clk);
    {sus, stp, in2, in1, out0, in0, kbd, tmr} = 8'h00;
    reg_wr = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(8'h00, pa, pb, 1'b0, reg_addr, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    seed_v = $urandom(32'h0051_7A2B);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 8; a++) peek("R1 reset read", 3'(a), 8'h00);
    peek_irq("R1 reset irq", 1'b0);

    // R5 flag registers cannot be written
    step(8'h00, 1, 1, 1, 3'd0, 8'hFF);
    step(8'h00, 1, 1, 1, 3'd4, 8'hFF);
    peek("R5 fn flag write", 3'd0, 8'h00);
    peek("R5 bus flag write", 3'd4, 8'h00);
    peek("R5 clear reads zero", 3'd1, 8'h00);

    // R2 timer and keyboard bits
    step(8'h03, 1, 1, 0, 3'd0, 8'h00);
    peek("R2 tmr kbd", 3'd0, 8'h09);
    peek_irq("R6 disabled flag no irq", 1'b0);

    // R7 pin A falling edge: set at third edge
    step(8'h00, 0, 1, 0, 3'd0, 8'h00);
    step(8'h00, 0, 1, 0, 3'd0, 8'h00);
    peek("R7 pin A early", 3'd0, 8'h09);
    step(8'h00, 0, 1, 0, 3'd0, 8'h00);
    peek("R7 pin A set", 3'd0, 8'h0B);
    // pin B
    step(8'h00, 0, 0, 0, 3'd0, 8'h00);
    step(8'h00, 0, 0, 0, 3'd0, 8'h00);
    step(8'h00, 0, 0, 0, 3'd0, 8'h00);
    peek("R2 pin B bit2", 3'd0, 8'h0F);

    // R4 clear semantics
    step(8'h00, 0, 0, 1, 3'd1, 8'h00);
    peek("R4 zero clear no effect", 3'd0, 8'h0F);
    step(8'h00, 0, 0, 1, 3'd1, 8'h05);
    peek("R4 partial clear", 3'd0, 8'h0A);
    step(8'h00, 0, 0, 1, 3'd1, 8'hFF);
    peek("R4 full clear", 3'd0, 8'h00);

    // R7 rising edges set nothing
    step(8'h00, 1, 1, 0, 3'd0, 8'h00);
    idle(4);
    peek("R7 rising no effect", 3'd0, 8'h00);

    // R3 bus layout
    step(8'hFC, 1, 1, 0, 3'd4, 8'h00);
    peek("R3 bus layout", 3'd4, 8'hCF);

    // R6 irq gating
    step(8'h00, 1, 1, 1, 3'd6, 8'h40);
    peek("R9 bus enable", 3'd6, 8'h40);
    peek_irq("R6 enabled flag irq", 1'b1);
    step(8'h00, 1, 1, 1, 3'd5, 8'h40);
    peek("R6 latched while disabled", 3'd4, 8'h8F);
    peek_irq("R6 irq drops", 1'b0);

    // R8 set and clear in the same cycle
    step(8'h40, 1, 1, 1, 3'd5, 8'h40);
    peek("R8 set wins", 3'd4, 8'hCF);
    peek_irq("R8 irq kept", 1'b1);

    // R9 enable masks
    step(8'h00, 1, 1, 1, 3'd2, 8'hFF);
    peek("R9 fn enable mask", 3'd2, 8'h0F);
    step(8'h00, 1, 1, 1, 3'd6, 8'hFF);
    peek("R9 bus enable mask", 3'd6, 8'hCF);
    peek("R5 hole reads zero", 3'd7, 8'h00);

    step(8'h00, 1, 1, 1, 3'd5, 8'hFF);
    step(8'h00, 1, 1, 1, 3'd6, 8'h00);

    // Constrained random phase, checked against the model every cycle
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] p;
      logic npa, npb, wr;
      logic [2:0] a;
      logic [7:0] d;
      for (int b = 0; b < 8; b++) p[b] = ($urandom % 9) == 0;
      npa = (($urandom % 6) == 0) ? ~pa : pa;
      npb = (($urandom % 6) == 0) ? ~pb : pb;
      wr  = ($urandom % 3) == 0;
      a   = 3'($urandom);
      d   = 8'($urandom);
      step(p, npa, npb, wr, a, d);
    end
    idle(4);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule